// File: doc/BRIEF.md
# Gated Peak Detector with Read-Clear

This block receives the digitized echo stream of whichever transducer channel is firing. Each sample arrives with the number of its channel. The block first conditions every sample into an unsigned amplitude. It then tests the sample against a set of programmable time windows. Each window is measured in samples from the most recent pulse-start strobe. For every pair of channel and window, the block keeps the largest amplitude seen and the sample index at which that amplitude occurred (the time of flight).

The host reads the results far less often than the transducers fire, so a held peak normally covers many pulses. A read names a channel and a gate. One cycle later the block returns the held result, tagged with that channel and gate, and the same read empties the entry so that a new maximum starts to build. If a sample that qualifies for the entry arrives in the same cycle as the read, the read returns the old content and that sample becomes the first value of the emptied entry.

Top module: `gated_peak_detector`

## Requirements
- R1: After reset, rd_valid is low and every entry is empty: a read returns rd_seen=0, rd_peak=0 and rd_tof=0.
- R2: cond_mode selects how each sample becomes an amplitude. 2'b00 gives the absolute value. 2'b01 passes positive samples and maps negative samples to 0. 2'b10 gives the magnitude of negative samples and maps positive samples to 0. 2'b11 behaves like 2'b00. An input of -2^(SAMPLE_W-1) yields the amplitude 2^(SAMPLE_W-1).
- R3: A sample accompanying pulse_start has index 0, and each later sample_valid cycle adds one. Gate g (start field at bits g*TIME_W of gate_start, width field at the same bits of gate_width) accepts index i when start <= i < start+width. A width of 0 disables the gate. Samples before the first pulse_start after reset are ignored.
- R4: The first accepted sample of an empty entry always fills it. After that, a sample replaces the held peak only when its amplitude is strictly greater, so on a tie the earlier sample is kept.
- R5: Each entry holds the index of the sample that produced its peak as the time of flight.
- R6: A sample updates only entries belonging to its sample_chan. Entries of other channels are unchanged.
- R7: A read with rd_req high produces rd_valid on the following cycle, with rd_chan_tag and rd_gate_tag equal to the requested channel and gate. When rd_req is low, rd_valid is low on the following cycle.
- R8: A read empties the addressed entry, so a second read with no qualifying sample in between returns rd_seen=0, rd_peak=0, rd_tof=0.
- R9: When a qualifying sample arrives in the same cycle as a read of its entry, the read returns the previous content and the entry then holds that sample, whatever its amplitude.
- R10: The sample index saturates at 2^TIME_W-1. Samples after that point keep this index until the next pulse_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_mode | input | 2 | Amplitude conditioning select |
| gate_start | input | NUM_GATES*TIME_W | Start index of each gate |
| gate_width | input | NUM_GATES*TIME_W | Length of each gate in samples, 0 disables it |
| pulse_start | input | 1 | Strobe marking index 0 of a new pulse |
| sample_valid | input | 1 | A sample is present this cycle |
| sample_chan | input | CH_W | Channel of the present sample |
| sample_data | input | SAMPLE_W | Signed two's-complement sample |
| rd_req | input | 1 | Destructive read request |
| rd_chan | input | CH_W | Channel to read |
| rd_gate | input | GATE_W | Gate to read |
| rd_valid | output | 1 | Read result present |
| rd_chan_tag | output | CH_W | Channel the result belongs to |
| rd_gate_tag | output | GATE_W | Gate the result belongs to |
| rd_seen | output | 1 | At least one sample was accepted since the last clear |
| rd_peak | output | SAMPLE_W | Held peak amplitude |
| rd_tof | output | TIME_W | Sample index of the held peak |

## Verification
A corrupted entry stays hidden until that entry is read. It then shows up in the very next cycle as a wrong peak, time of flight or seen flag, so every result is compared against an independent behavioural model on every read. A sample index that drifts shows up as wrong time-of-flight values and as samples landing in the wrong gates on the first read after the pulse concerned. A clear that is missed, or a clear that loses a racing sample, shows up only on the read after the next one, so reads are issued back to back on the same entry, including in the cycle of a racing sample.

// File: rtl/gpd_pkg.sv
package gpd_pkg;

  typedef enum logic [1:0] {
    COND_FULL = 2'd0,
    COND_POS  = 2'd1,
    COND_NEG  = 2'd2,
    COND_ALT  = 2'd3
  } cond_mode_e;

  // Window membership: start <= idx < start + width, width 0 means disabled.
  function automatic logic in_gate(input int unsigned idx,
                                   input int unsigned start,
                                   input int unsigned width);
    return (width != 0) && (idx >= start) && ((idx - start) < width);
  endfunction

endpackage

// File: rtl/gpd_condition.sv
module gpd_condition #(
  parameter int SAMPLE_W = 11
) (
  input  logic [1:0]                 mode,
  input  logic signed [SAMPLE_W-1:0] smp,
  output logic [SAMPLE_W-1:0]        mag
);
  import gpd_pkg::*;

  logic [SAMPLE_W-1:0] negated;
  logic                is_neg;

  assign is_neg  = smp[SAMPLE_W-1];
  // Two's-complement negation in SAMPLE_W bits; the most negative code maps to 2^(SAMPLE_W-1).
  assign negated = ~smp + 1'b1;

  always_comb begin
    case (cond_mode_e'(mode))
      COND_POS: mag = is_neg ? '0 : $unsigned(smp);
      COND_NEG: mag = is_neg ? negated : '0;
      default:  mag = is_neg ? negated : $unsigned(smp);
    endcase
  end

endmodule

// File: rtl/gpd_index.sv
module gpd_index #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_start,
  input  logic              sample_valid,
  output logic [TIME_W-1:0] cur_idx,
  output logic              armed
);
  localparam logic [TIME_W-1:0] IDX_MAX = '1;

  logic [TIME_W-1:0] cnt_q;
  logic              armed_q;

  assign cur_idx = pulse_start ? '0 : cnt_q;
  assign armed   = armed_q | pulse_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (sample_valid)
        cnt_q <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
      else if (pulse_start)
        cnt_q <= '0;
      armed_q <= armed_q | pulse_start;
    end
  end

endmodule

// File: rtl/gpd_window.sv
module gpd_window #(
  parameter int NUM_GATES = 4,
  parameter int TIME_W    = 16
) (
  input  logic [TIME_W-1:0]           cur_idx,
  input  logic [NUM_GATES*TIME_W-1:0] gate_start,
  input  logic [NUM_GATES*TIME_W-1:0] gate_width,
  output logic [NUM_GATES-1:0]        hit
);
  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    assign hit[g] = gpd_pkg::in_gate(32'(cur_idx),
                                     32'(gate_start[g*TIME_W +: TIME_W]),
                                     32'(gate_width[g*TIME_W +: TIME_W]));
  end

endmodule

// File: rtl/gpd_peak_bank.sv
module gpd_peak_bank #(
  parameter int SAMPLE_W     = 11,
  parameter int TIME_W       = 16,
  parameter int NUM_CHANNELS = 4,
  parameter int NUM_GATES    = 4
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             sample_en,
  input  logic [((NUM_CHANNELS > 1) ? $clog2(NUM_CHANNELS) : 1)-1:0] samp_chan,
  input  logic [NUM_GATES-1:0]                             hit,
  input  logic [SAMPLE_W-1:0]                              mag,
  input  logic [TIME_W-1:0]                                cur_idx,
  input  logic                                             rd_req,
  input  logic [((NUM_CHANNELS > 1) ? $clog2(NUM_CHANNELS) : 1)-1:0] rd_chan,
  input  logic [((NUM_GATES > 1) ? $clog2(NUM_GATES) : 1)-1:0]       rd_gate,
  output logic                                             rd_valid,
  output logic [((NUM_CHANNELS > 1) ? $clog2(NUM_CHANNELS) : 1)-1:0] rd_chan_tag,
  output logic [((NUM_GATES > 1) ? $clog2(NUM_GATES) : 1)-1:0]       rd_gate_tag,
  output logic                                             rd_seen,
  output logic [SAMPLE_W-1:0]                              rd_peak,
  output logic [TIME_W-1:0]                                rd_tof,
  output logic [NUM_CHANNELS*NUM_GATES-1:0]                take_vec
);
  localparam int CH_W    = (NUM_CHANNELS > 1) ? $clog2(NUM_CHANNELS) : 1;
  localparam int GATE_W  = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1;
  localparam int ENTRIES = NUM_CHANNELS * NUM_GATES;

  logic [SAMPLE_W-1:0] peak_q [ENTRIES];
  logic [TIME_W-1:0]   tof_q  [ENTRIES];
  logic [ENTRIES-1:0]  seen_q;
  logic [ENTRIES-1:0]  rd_sel;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    localparam int CI = e / NUM_GATES;
    localparam int GI = e % NUM_GATES;
    logic upd;

    assign upd         = sample_en && (samp_chan == CH_W'(CI)) && hit[GI];
    assign rd_sel[e]   = rd_req && (rd_chan == CH_W'(CI)) && (rd_gate == GATE_W'(GI));
    // A racing read empties the entry first, so the sample always seeds it.
    assign take_vec[e] = upd && (rd_sel[e] || !seen_q[e] || (mag > peak_q[e]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        peak_q[e] <= '0;
        tof_q[e]  <= '0;
        seen_q[e] <= 1'b0;
      end else if (take_vec[e]) begin
        peak_q[e] <= mag;
        tof_q[e]  <= cur_idx;
        seen_q[e] <= 1'b1;
      end else if (rd_sel[e]) begin
        peak_q[e] <= '0;
        tof_q[e]  <= '0;
        seen_q[e] <= 1'b0;
      end
    end
  end

  logic [SAMPLE_W-1:0] mux_peak;
  logic [TIME_W-1:0]   mux_tof;
  logic                mux_seen;

  always_comb begin
    mux_peak = '0;
    mux_tof  = '0;
    mux_seen = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (rd_sel[e]) begin
        mux_peak = peak_q[e];
        mux_tof  = tof_q[e];
        mux_seen = seen_q[e];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid    <= 1'b0;
      rd_chan_tag <= '0;
      rd_gate_tag <= '0;
      rd_seen     <= 1'b0;
      rd_peak     <= '0;
      rd_tof      <= '0;
    end else begin
      rd_valid    <= rd_req;
      rd_chan_tag <= rd_chan;
      rd_gate_tag <= rd_gate;
      rd_seen     <= mux_seen;
      rd_peak     <= mux_peak;
      rd_tof      <= mux_tof;
    end
  end

endmodule

// File: rtl/gated_peak_detector.sv
module gated_peak_detector #(
  parameter int SAMPLE_W     = 11,
  parameter int TIME_W       = 16,
  parameter int NUM_CHANNELS = 4,
  parameter int NUM_GATES    = 4,
  localparam int CH_W        = (NUM_CHANNELS > 1) ? $clog2(NUM_CHANNELS) : 1,
  localparam int GATE_W      = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    cond_mode,
  input  logic [NUM_GATES*TIME_W-1:0]   gate_start,
  input  logic [NUM_GATES*TIME_W-1:0]   gate_width,
  input  logic                          pulse_start,
  input  logic                          sample_valid,
  input  logic [CH_W-1:0]               sample_chan,
  input  logic signed [SAMPLE_W-1:0]    sample_data,
  input  logic                          rd_req,
  input  logic [CH_W-1:0]               rd_chan,
  input  logic [GATE_W-1:0]             rd_gate,
  output logic                          rd_valid,
  output logic [CH_W-1:0]               rd_chan_tag,
  output logic [GATE_W-1:0]             rd_gate_tag,
  output logic                          rd_seen,
  output logic [SAMPLE_W-1:0]           rd_peak,
  output logic [TIME_W-1:0]             rd_tof
);
  localparam int ENTRIES = NUM_CHANNELS * NUM_GATES;

  // Internal events brought out by name for the checker.
  logic [TIME_W-1:0]    cur_idx;
  logic                 armed_now;
  logic [NUM_GATES-1:0] gate_hit;
  logic [SAMPLE_W-1:0]  cond_mag;
  logic [ENTRIES-1:0]   take_vec;
  logic                 sample_en;

  assign sample_en = sample_valid && armed_now;

  gpd_condition #(.SAMPLE_W(SAMPLE_W)) u_cond (
    .mode (cond_mode),
    .smp  (sample_data),
    .mag  (cond_mag)
  );

  gpd_index #(.TIME_W(TIME_W)) u_index (
    .clk          (clk),
    .rst_n        (rst_n),
    .pulse_start  (pulse_start),
    .sample_valid (sample_valid),
    .cur_idx      (cur_idx),
    .armed        (armed_now)
  );

  gpd_window #(.NUM_GATES(NUM_GATES), .TIME_W(TIME_W)) u_window (
    .cur_idx    (cur_idx),
    .gate_start (gate_start),
    .gate_width (gate_width),
    .hit        (gate_hit)
  );

  gpd_peak_bank #(
    .SAMPLE_W     (SAMPLE_W),
    .TIME_W       (TIME_W),
    .NUM_CHANNELS (NUM_CHANNELS),
    .NUM_GATES    (NUM_GATES)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en   (sample_en),
    .samp_chan   (sample_chan),
    .hit         (gate_hit),
    .mag         (cond_mag),
    .cur_idx     (cur_idx),
    .rd_req      (rd_req),
    .rd_chan     (rd_chan),
    .rd_gate     (rd_gate),
    .rd_valid    (rd_valid),
    .rd_chan_tag (rd_chan_tag),
    .rd_gate_tag (rd_gate_tag),
    .rd_seen     (rd_seen),
    .rd_peak     (rd_peak),
    .rd_tof      (rd_tof),
    .take_vec    (take_vec)
  );

endmodule

// File: rtl/gpd_chk.sv
module gpd_chk #(
  parameter int SAMPLE_W     = 11,
  parameter int TIME_W       = 16,
  parameter int NUM_CHANNELS = 4,
  parameter int NUM_GATES    = 4,
  localparam int CH_W        = (NUM_CHANNELS > 1) ? $clog2(NUM_CHANNELS) : 1,
  localparam int GATE_W      = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1,
  localparam int ENTRIES     = NUM_CHANNELS * NUM_GATES
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [1:0]                 cond_mode,
  input logic                       pulse_start,
  input logic                       sample_valid,
  input logic [SAMPLE_W-1:0]        sample_data,
  input logic                       rd_req,
  input logic [CH_W-1:0]            rd_chan,
  input logic [GATE_W-1:0]          rd_gate,
  input logic                       rd_valid,
  input logic [CH_W-1:0]            rd_chan_tag,
  input logic [GATE_W-1:0]          rd_gate_tag,
  input logic                       rd_seen,
  input logic [SAMPLE_W-1:0]        rd_peak,
  input logic [TIME_W-1:0]          rd_tof,
  input logic [TIME_W-1:0]          cur_idx,
  input logic                       armed_now,
  input logic [SAMPLE_W-1:0]        cond_mag,
  input logic [ENTRIES-1:0]         take_vec
);
  import gpd_pkg::*;
  localparam logic [TIME_W-1:0] IDX_MAX = '1;

  p_rd_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  p_rd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  p_rd_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (rd_chan_tag == $past(rd_chan)) && (rd_gate_tag == $past(rd_gate)));

  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_seen) |-> (rd_peak == '0) && (rd_tof == '0));

  p_unarmed_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_now |-> (take_vec == '0));

  p_no_sample_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> (take_vec == '0));

  p_pos_clip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_mode == COND_POS && sample_data[SAMPLE_W-1]) |-> (cond_mag == '0));

  p_neg_clip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_mode == COND_NEG && !sample_data[SAMPLE_W-1]) |-> (cond_mag == '0));

  p_idx_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_idx == IDX_MAX && sample_valid && !pulse_start) |=> (pulse_start || cur_idx == IDX_MAX));

endmodule

bind gated_peak_detector gpd_chk #(
  .SAMPLE_W     (SAMPLE_W),
  .TIME_W       (TIME_W),
  .NUM_CHANNELS (NUM_CHANNELS),
  .NUM_GATES    (NUM_GATES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cond_mode    (cond_mode),
  .pulse_start  (pulse_start),
  .sample_valid (sample_valid),
  .sample_data  (sample_data),
  .rd_req       (rd_req),
  .rd_chan      (rd_chan),
  .rd_gate      (rd_gate),
  .rd_valid     (rd_valid),
  .rd_chan_tag  (rd_chan_tag),
  .rd_gate_tag  (rd_gate_tag),
  .rd_seen      (rd_seen),
  .rd_peak      (rd_peak),
  .rd_tof       (rd_tof),
  .cur_idx      (cur_idx),
  .armed_now    (armed_now),
  .cond_mag     (cond_mag),
  .take_vec     (take_vec)
);

// File: tb/gated_peak_detector_tb.sv
module gated_peak_detector_tb;
  localparam int SW = 11;
  localparam int TW = 6;
  localparam int NC = 4;
  localparam int NG = 4;
  localparam int CW = 2;
  localparam int GW = 2;
  localparam int IDX_MAX = (1 << TW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [1:0]        cond_mode;
  logic [NG*TW-1:0]  gate_start, gate_width;
  logic              pulse_start, sample_valid;
  logic [CW-1:0]     sample_chan;
  logic [SW-1:0]     sample_data;
  logic              rd_req;
  logic [CW-1:0]     rd_chan;
  logic [GW-1:0]     rd_gate;
  logic              rd_valid;
  logic [CW-1:0]     rd_chan_tag;
  logic [GW-1:0]     rd_gate_tag;
  logic              rd_seen;
  logic [SW-1:0]     rd_peak;
  logic [TW-1:0]     rd_tof;

  int g_st[NG];
  int g_wd[NG];

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      gate_start[g*TW +: TW] = TW'(g_st[g]);
      gate_width[g*TW +: TW] = TW'(g_wd[g]);
    end
  end

  gated_peak_detector #(.SAMPLE_W(SW), .TIME_W(TW), .NUM_CHANNELS(NC), .NUM_GATES(NG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cond_mode(cond_mode), .gate_start(gate_start),
    .gate_width(gate_width), .pulse_start(pulse_start), .sample_valid(sample_valid),
    .sample_chan(sample_chan), .sample_data(sample_data), .rd_req(rd_req),
    .rd_chan(rd_chan), .rd_gate(rd_gate), .rd_valid(rd_valid),
    .rd_chan_tag(rd_chan_tag), .rd_gate_tag(rd_gate_tag), .rd_seen(rd_seen),
    .rd_peak(rd_peak), .rd_tof(rd_tof)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_peak[NC][NG];
  int m_tof[NC][NG];
  bit m_seen[NC][NG];
  int m_cnt;
  bit m_armed;
  bit e_valid;
  int e_chan, e_gate, e_peak, e_tof;
  bit e_seen;

  function automatic int amp_ref(input int v, input int mode);
    case (mode)
      1:       return (v > 0) ? v : 0;
      2:       return (v < 0) ? -v : 0;
      default: return (v < 0) ? -v : v;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++)
        for (int g = 0; g < NG; g++) begin
          m_peak[c][g] = 0; m_tof[c][g] = 0; m_seen[c][g] = 0;
        end
      m_cnt = 0; m_armed = 0; e_valid = 0;
    end else begin
      int idx;
      int a;
      int c;
      idx = pulse_start ? 0 : m_cnt;
      e_valid = rd_req;
      if (rd_req) begin
        e_chan = int'(rd_chan); e_gate = int'(rd_gate);
        e_peak = m_peak[e_chan][e_gate];
        e_tof  = m_tof[e_chan][e_gate];
        e_seen = m_seen[e_chan][e_gate];
        m_peak[e_chan][e_gate] = 0; m_tof[e_chan][e_gate] = 0; m_seen[e_chan][e_gate] = 0;
      end
      if (sample_valid && (m_armed || pulse_start)) begin
        a = amp_ref(int'($signed(sample_data)), int'(cond_mode));
        c = int'(sample_chan);
        for (int g = 0; g < NG; g++) begin
          if (g_wd[g] != 0 && idx >= g_st[g] && idx < g_st[g] + g_wd[g]) begin
            if (!m_seen[c][g] || a > m_peak[c][g]) begin
              m_peak[c][g] = a; m_tof[c][g] = idx; m_seen[c][g] = 1;
            end
          end
        end
      end
      if (sample_valid) m_cnt = (idx < IDX_MAX) ? idx + 1 : IDX_MAX;
      else if (pulse_start) m_cnt = 0;
      if (pulse_start) m_armed = 1;
    end
  end

  // R7: every cycle, port results against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rd_valid == e_valid, "R7", "model rd_valid", int'(rd_valid), int'(e_valid));
      if (e_valid && rd_valid) begin
        check(int'(rd_chan_tag) == e_chan, "R7", "model chan tag", int'(rd_chan_tag), e_chan);
        check(int'(rd_gate_tag) == e_gate, "R7", "model gate tag", int'(rd_gate_tag), e_gate);
        check(rd_seen == e_seen, "R7", "model seen", int'(rd_seen), int'(e_seen));
        check(int'(rd_peak) == e_peak, "R7", "model peak", int'(rd_peak), e_peak);
        check(int'(rd_tof) == e_tof, "R7", "model tof", int'(rd_tof), e_tof);
      end
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic step(input bit ps, input bit sv, input int ch, input int val,
                      input bit rq, input int rc, input int rg);
    pulse_start  = ps;
    sample_valid = sv;
    sample_chan  = CW'(ch);
    sample_data  = SW'(val);
    rd_req       = rq;
    rd_chan      = CW'(rc);
    rd_gate      = GW'(rg);
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_result(input string tag, input int ch, input int g,
                               input bit es, input int ep, input int et);
    check(rd_valid == 1'b1, tag, "rd_valid", int'(rd_valid), 1);
    check(int'(rd_chan_tag) == ch && int'(rd_gate_tag) == g, tag, "tags chan*4+gate",
          int'(rd_chan_tag) * 4 + int'(rd_gate_tag), ch * 4 + g);
    check(rd_seen == es, tag, "seen", int'(rd_seen), int'(es));
    check(int'(rd_peak) == ep, tag, "peak", int'(rd_peak), ep);
    check(int'(rd_tof) == et, tag, "tof", int'(rd_tof), et);
  endtask

  task automatic read_chk(input string tag, input int ch, input int g,
                          input bit es, input int ep, input int et);
    step(0, 0, 0, 0, 1, ch, g);
    expect_result(tag, ch, g, es, ep, et);
  endtask

  function automatic int stream_val(input int i);
    case (i)
      0: return 900;   1: return -800; 2: return 100;  3: return -350;
      4: return 200;   5: return -350; 6: return 999;  10: return -20;
      11: return 30;   12: return -30; 13: return 1000;
      default: return 0;
    endcase
  endfunction

  task automatic send_stream(input int ch);
    for (int i = 0; i < 14; i++) step(i == 0, 1, ch, stream_val(i), 0, 0, 0);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    rst_n = 0; cond_mode = 2'd0;
    pulse_start = 0; sample_valid = 0; sample_chan = '0; sample_data = '0;
    rd_req = 0; rd_chan = '0; rd_gate = '0;
    g_st[0] = 2;  g_wd[0] = 4;
    g_st[1] = 10; g_wd[1] = 3;
    g_st[2] = 4;  g_wd[2] = 8;
    g_st[3] = 0;  g_wd[3] = 0;
    repeat (3) @(negedge clk);
    check(rd_valid == 1'b0, "R1", "rd_valid in reset", int'(rd_valid), 0);
    rst_n = 1;
    idle();
    check(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
    read_chk("R1", 0, 0, 0, 0, 0);

    // R3: samples before any pulse_start are ignored
    for (int i = 0; i < 5; i++) step(0, 1, 0, 500, 0, 0, 0);
    read_chk("R3", 0, 0, 0, 0, 0);

    // Full rectification on channel 1
    cond_mode = 2'd0;
    send_stream(1);
    idle();
    read_chk("R4", 1, 0, 1, 350, 3);
    read_chk("R5", 1, 1, 1, 30, 11);
    read_chk("R2", 1, 2, 1, 999, 6);
    read_chk("R3", 1, 3, 0, 0, 0);
    read_chk("R6", 0, 0, 0, 0, 0);
    read_chk("R8", 1, 0, 0, 0, 0);

    // Positive polarity on channel 2
    cond_mode = 2'd1;
    send_stream(2);
    read_chk("R2", 2, 0, 1, 200, 4);
    read_chk("R2", 2, 1, 1, 30, 11);

    // Negative polarity on channel 3
    cond_mode = 2'd2;
    send_stream(3);
    read_chk("R2", 3, 0, 1, 350, 3);
    read_chk("R2", 3, 1, 1, 30, 12);
    read_chk("R2", 3, 2, 1, 350, 5);

    // Mode 3 acts as full rectification, most negative code
    cond_mode = 2'd3;
    step(1, 1, 2, 0, 0, 0, 0);
    step(0, 1, 2, 0, 0, 0, 0);
    step(0, 1, 2, -1024, 0, 0, 0);
    read_chk("R2", 2, 0, 1, 1024, 2);

    // R9: read races a qualifying sample
    cond_mode = 2'd0;
    step(1, 1, 1, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0, 0);
    step(0, 1, 1, 40, 0, 0, 0);
    step(0, 1, 1, 5, 1, 1, 0);
    expect_result("R9", 1, 0, 1, 40, 2);
    idle();
    read_chk("R9", 1, 0, 1, 5, 3);

    // R10: index saturation
    g_st[3] = 62; g_wd[3] = 4;
    step(1, 1, 0, 0, 0, 0, 0);
    for (int i = 1; i < 70; i++) step(0, 1, 0, i, 0, 0, 0);
    read_chk("R10", 0, 3, 1, 69, 63);
    read_chk("R4", 0, 0, 1, 5, 5);
    read_chk("R4", 0, 2, 1, 11, 11);

    repeat (3) idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule